// File: doc/BRIEF.md
# Byte-Lane Strobe Generator

This block sits beside the pass-through cycle sequencer of a bus bridge. It samples the sequencer's 4-bit state code, the 2-bit region class of the current transfer, the four active-low pending byte enables and an alternate-bus select. On each clock edge it registers the bridge's active-low byte enables, an active-low chip select and a drive-enable, and it presents a constant 5-bit register address.

A single 32-bit pass-through transfer into a narrow region is split into successive lane accesses. For a byte-wide region one lane is issued per data step. For a halfword region one lane pair is issued per data step. In both cases the lowest lane that is still pending goes first. For word-wide regions the pending enables pass straight through.

Chip-select timing depends on the region and on the burst phase. A first-data-phase flag is used to tell the first phase of a burst from the later ones. When the alternate bus owns the bridge, the drive-enable drops and every strobe is held inactive, so the outputs can be released.

Top module: `lane_strobe_gen`

## Requirements
- R1: While reset is asserted, be_n is 4'hF, sel_n is 1 and drv_en is 0.
- R2: Every output is registered and reflects the inputs sampled at the previous clock edge. reg_addr always equals the parameter REG_ADDR.
- R3: Region 2'b00 (byte-wide) in state code 6: exactly one be_n bit is low. It is the lowest index i for which pend_be_n[i] is 0. If no pending bit is low, be_n is 4'hF.
- R4: Region 2'b01 (halfword) in state code 6: be_n is 4'b1100 when pend_be_n[0] or pend_be_n[1] is 0. Otherwise it is 4'b0011 when pend_be_n[2] or pend_be_n[3] is 0. Otherwise it is 4'hF.
- R5: Regions 2'b10 (medium word) and 2'b11 (fast word) in state code 6: be_n equals pend_be_n.
- R6: For any state code other than 6, including codes 9 to 15, be_n is 4'hF.
- R7: sel_n is low for state codes 3 to 8 in regions 2'b00 and 2'b01. It is low for codes 5 and 6 in region 2'b10, and for code 6 in region 2'b11.
- R8: In region 2'b11, sel_n is also low in state code 2, but only when the first-phase flag is clear. The flag is set by sampling code 1 and cleared by sampling code 6.
- R9: In regions 2'b10 and 2'b11, sel_n is low in state code 0 only when the previously sampled code was 6. The select therefore lasts one clock after a transfer ends.
- R10: While alt_bus is 1, drv_en is 0, be_n is 4'hF and sel_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_code | input | 4 | Sequencer state code, 0 to 8 |
| region | input | 2 | Region class: 00 byte, 01 halfword, 10 medium word, 11 fast word |
| pend_be_n | input | 4 | Active-low byte enables still pending |
| alt_bus | input | 1 | Alternate-bus mode select |
| be_n | output | 4 | Active-low byte enables to the bridge |
| sel_n | output | 1 | Active-low chip select to the bridge |
| reg_addr | output | 5 | Fixed data-register address |
| drv_en | output | 1 | High when the outputs are driven, low when released |

## Verification
Several properties are checked on every cycle:
- Byte-wide regions never show more than one active lane.
- Halfword regions only ever show a whole pair.
- The enables stay idle outside code 6.
- The alternate-bus release forces every strobe inactive.
- A select in code 0 is always preceded by code 6.

Other behaviour can only be shown by the bench's scenarios:
- The lowest-first order of lanes across a whole split transfer.
- The suppressed select in the first code 2 of a fast burst and its presence in later ones.
- The single-clock end-of-transfer select in word regions.

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen #(
  parameter logic [4:0] REG_ADDR = 5'h1C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] state_code,
  input  logic [1:0] region,
  input  logic [3:0] pend_be_n,
  input  logic       alt_bus,
  output logic [3:0] be_n,
  output logic       sel_n,
  output logic [4:0] reg_addr,
  output logic       drv_en
);

  localparam logic [1:0] RG_BYTE = 2'b00;
  localparam logic [1:0] RG_HALF = 2'b01;
  localparam logic [1:0] RG_MED  = 2'b10;
  localparam logic [1:0] RG_FAST = 2'b11;

  logic [3:0] prev_code;
  logic       first_ph;
  logic [3:0] be_nxt;
  logic       sel_act;

  assign reg_addr = REG_ADDR;

  always_comb begin
    be_nxt = 4'hF;
    case (region)
      RG_BYTE: begin
        for (int i = 3; i >= 0; i--)
          if (!pend_be_n[i]) be_nxt = ~(4'b0001 << i);
      end
      RG_HALF: begin
        if (!(pend_be_n[0] & pend_be_n[1]))      be_nxt = 4'b1100;
        else if (!(pend_be_n[2] & pend_be_n[3])) be_nxt = 4'b0011;
      end
      default: be_nxt = pend_be_n;
    endcase
    if (state_code != 4'd6 || alt_bus) be_nxt = 4'hF;
  end

  wire end_sel = (state_code == 4'd0) && (prev_code == 4'd6);

  always_comb begin
    case (region)
      RG_BYTE, RG_HALF: sel_act = (state_code >= 4'd3) && (state_code <= 4'd8);
      RG_MED:  sel_act = (state_code == 4'd5) || (state_code == 4'd6) || end_sel;
      RG_FAST: sel_act = (state_code == 4'd6) || end_sel ||
                         ((state_code == 4'd2) && !first_ph);
      default: sel_act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_n      <= 4'hF;
      sel_n     <= 1'b1;
      drv_en    <= 1'b0;
      prev_code <= 4'd0;
      first_ph  <= 1'b0;
    end else begin
      be_n      <= be_nxt;
      sel_n     <= ~(sel_act && !alt_bus);
      drv_en    <= ~alt_bus;
      prev_code <= state_code;
      if (state_code == 4'd1)      first_ph <= 1'b1;
      else if (state_code == 4'd6) first_ph <= 1'b0;
    end
  end

  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(region) == RG_BYTE) |-> ($countones(~be_n) <= 1));

  a_r4_whole_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(region) == RG_HALF) |-> (be_n == 4'hF || be_n == 4'b1100 || be_n == 4'b0011));

  a_r6_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_code) != 4'd6) |-> (be_n == 4'hF));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alt_bus) |-> (!drv_en && be_n == 4'hF && sel_n));

  a_r9_end_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $past(state_code) == 4'd0) |-> ($past(state_code, 2) == 4'd6 && $past(region[1])));

  a_r2_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == REG_ADDR);

endmodule

// File: tb/test_lane_strobe_gen.sv
module test_lane_strobe_gen;
  localparam logic [4:0] ADDR = 5'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] state_code = 4'd0;
  logic [1:0] region = 2'b00;
  logic [3:0] pend_be_n = 4'hF;
  logic       alt_bus = 1'b0;
  logic [3:0] be_n;
  logic       sel_n;
  logic [4:0] reg_addr;
  logic       drv_en;

  lane_strobe_gen #(.REG_ADDR(ADDR)) i_lane_strobe_gen (
    .clk(clk), .rst_n(rst_n), .state_code(state_code), .region(region),
    .pend_be_n(pend_be_n), .alt_bus(alt_bus), .be_n(be_n), .sel_n(sel_n),
    .reg_addr(reg_addr), .drv_en(drv_en));

  always #4 clk = ~clk;

  typedef struct {
    logic [3:0] be;
    logic       sel;
    logic       drv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [3:0] m_prev = 4'd0;
  logic       m_first = 1'b0;

  function automatic logic [3:0] exp_be(input logic [3:0] st, input logic [1:0] rg,
                                        input logic [3:0] pd, input logic al);
    logic [3:0] r;
    r = 4'hF;
    if (al || st != 4'd6) return r;
    if (rg == 2'b00) begin
      for (int i = 0; i < 4; i++)
        if (!pd[i]) begin r = 4'hF; r[i] = 1'b0; return r; end
    end else if (rg == 2'b01) begin
      if (pd[1:0] != 2'b11) r = 4'b1100;
      else if (pd[3:2] != 2'b11) r = 4'b0011;
    end else r = pd;
    return r;
  endfunction

  function automatic logic exp_sel(input logic [3:0] st, input logic [1:0] rg, input logic al);
    logic a;
    if (al) return 1'b1;
    case (rg)
      2'b00, 2'b01: a = (st >= 3 && st <= 8);
      2'b10: a = (st == 5 || st == 6 || (st == 0 && m_prev == 6));
      default: a = (st == 6 || (st == 2 && !m_first) || (st == 0 && m_prev == 6));
    endcase
    return ~a;
  endfunction

  task automatic step(input logic [3:0] st, input logic [1:0] rg, input logic [3:0] pd,
                      input logic al, input string tag);
    exp_t e;
    @(negedge clk);
    state_code = st; region = rg; pend_be_n = pd; alt_bus = al;
    e.be = exp_be(st, rg, pd, al);
    e.sel = exp_sel(st, rg, al);
    e.drv = ~al;
    e.tag = tag;
    q.push_back(e);
    m_prev = st;
    if (st == 4'd1) m_first = 1'b1;
    else if (st == 4'd6) m_first = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (be_n !== e.be || sel_n !== e.sel || drv_en !== e.drv || reg_addr !== ADDR) begin
          n_bad++;
          $display("FAIL %s: be_n=%b sel_n=%b drv_en=%b addr=%h, expected be_n=%b sel_n=%b drv_en=%b addr=%h",
                   e.tag, be_n, sel_n, drv_en, reg_addr, e.be, e.sel, e.drv, ADDR);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (be_n !== 4'hF || sel_n !== 1'b1 || drv_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: be_n=%b sel_n=%b drv_en=%b, expected 1111 1 0", be_n, sel_n, drv_en);
    end
    rst_n = 1'b1;

    // R3 byte-wide split transfer, all lanes pending, lowest first
    step(0, 2'b00, 4'b0000, 0, "R2");
    step(1, 2'b00, 4'b0000, 0, "R6");
    step(2, 2'b00, 4'b0000, 0, "R7");
    step(3, 2'b00, 4'b0000, 0, "R7");
    step(4, 2'b00, 4'b0000, 0, "R7");
    step(5, 2'b00, 4'b0000, 0, "R7");
    step(6, 2'b00, 4'b0000, 0, "R3");
    step(7, 2'b00, 4'b1110, 0, "R7");
    step(2, 2'b00, 4'b1110, 0, "R7");
    step(6, 2'b00, 4'b1110, 0, "R3");
    step(7, 2'b00, 4'b1100, 0, "R7");
    step(6, 2'b00, 4'b1011, 0, "R3");
    step(6, 2'b00, 4'b0111, 0, "R3");
    step(6, 2'b00, 4'b1111, 0, "R3");
    step(8, 2'b00, 4'b1111, 0, "R7");
    step(0, 2'b00, 4'b1111, 0, "R9");
    // R4 halfword pairs
    step(1, 2'b01, 4'b0000, 0, "R6");
    step(2, 2'b01, 4'b0000, 0, "R7");
    step(3, 2'b01, 4'b0000, 0, "R7");
    step(6, 2'b01, 4'b0000, 0, "R4");
    step(7, 2'b01, 4'b1100, 0, "R7");
    step(6, 2'b01, 4'b1101, 0, "R4");
    step(6, 2'b01, 4'b1100, 0, "R4");
    step(6, 2'b01, 4'b0111, 0, "R4");
    step(6, 2'b01, 4'b1111, 0, "R4");
    step(8, 2'b01, 4'b1111, 0, "R7");
    step(0, 2'b01, 4'b1111, 0, "R9");
    // R5 medium word, end-of-transfer select
    step(1, 2'b10, 4'b1010, 0, "R6");
    step(2, 2'b10, 4'b1010, 0, "R7");
    step(5, 2'b10, 4'b1010, 0, "R7");
    step(6, 2'b10, 4'b1010, 0, "R5");
    step(0, 2'b10, 4'b1111, 0, "R9");
    step(0, 2'b10, 4'b1111, 0, "R9");
    step(3, 2'b10, 4'b1111, 0, "R7");
    // R8 fast burst
    step(1, 2'b11, 4'b0000, 0, "R6");
    step(2, 2'b11, 4'b0000, 0, "R8");
    step(6, 2'b11, 4'b0000, 0, "R5");
    step(2, 2'b11, 4'b0101, 0, "R8");
    step(6, 2'b11, 4'b0101, 0, "R5");
    step(2, 2'b11, 4'b0000, 0, "R8");
    step(6, 2'b11, 4'b0011, 0, "R5");
    step(0, 2'b11, 4'b1111, 0, "R9");
    step(0, 2'b11, 4'b1111, 0, "R9");
    step(5, 2'b11, 4'b1111, 0, "R7");
    // R10 alternate bus
    step(1, 2'b11, 4'b0000, 1, "R10");
    step(6, 2'b11, 4'b0000, 1, "R10");
    step(6, 2'b00, 4'b0000, 1, "R10");
    step(4, 2'b01, 4'b0000, 1, "R10");
    step(6, 2'b10, 4'b0000, 0, "R10");
    // R6 unused codes
    for (int c = 9; c < 16; c++) step(c[3:0], 2'b00, 4'b0000, 0, "R6");
    step(0, 2'b00, 4'b1111, 0, "R6");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule